// File: doc/BRIEF.md
# Register Machine with Pointer Operands

This block is a small program-driven register machine. A program of fixed-format instruction words sits in an internal store. The sequencer steps through it and acts on a bank of bounded natural-number registers. Every register operand of an instruction carries its own flag. When the flag is clear, the operand field is the register number. When the flag is set, the register named by the field is read first, and its contents become the register number. The two operands of a copy or compare can therefore dereference pointers independently, and a register may name itself as its own pointer.

The program is written through a plain write port while `rst_n` is low. Each strobe on that port stores one word, and the port has no back-pressure. Releasing reset starts execution at address 0. Every instruction takes two clock cycles. The first cycle latches the word and resolves both operand addresses through any pointer registers. The second cycle reads the targets, writes back the result and moves the instruction pointer. The run ends when a halt instruction executes, or when an operand resolves to a register number the bank does not have. The block then raises `halted` and freezes. A debug port reads any register at any time, and `ip` shows the instruction pointer.

Top module: `regm_core`

## Requirements
- R1: During and right after reset, `ip` is 0, `halted` and `fault` are 0, and every register reads 0 on the debug port, including registers written by an earlier run.
- R2: The instruction word, from MSB to LSB, is opcode[2:0], flag A, field A[RA_W-1:0], flag B, field B[RA_W-1:0], target z[PC_W-1:0]. The opcodes are 0 halt, 1 increment, 2 decrement, 3 clear, 4 copy, 5 jump-if-zero, 6 jump-if-equal and 7 jump. Each instruction takes exactly two cycles, so the k-th instruction (k from 0) completes on the (2k+2)-th rising edge after reset is released.
- R3: Increment adds one to operand A's register and saturates at the all-ones value. The pointer then advances by one.
- R4: Decrement subtracts one from operand A's register. A register holding 0 stays at 0. The pointer advances by one.
- R5: Clear writes 0 to operand A's register. Copy writes the value of operand B's register into operand A's register. Both advance the pointer by one.
- R6: With an operand's flag set, the register named by its field supplies the target register number. A register that names itself works as its own pointer.
- R7: All four flag combinations of a two-operand copy behave independently: direct/direct, pointer destination, pointer source, and both through pointers.
- R8: Jump-if-zero loads z into `ip` when operand A's register is 0, and otherwise advances by one.
- R9: Jump-if-equal loads z when the registers of operands A and B hold equal values, and otherwise advances by one.
- R10: Jump loads z unconditionally.
- R11: Halt sets `halted`. After that, `ip` and all registers stay unchanged.
- R12: If an operand that the opcode uses resolves to a register number of NREGS or more, the instruction writes nothing, and `fault` and `halted` both rise with `ip` left on the faulting instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; hold low while loading the program |
| ld_en | input | 1 | Program write strobe, one word per cycle |
| ld_addr | input | PC_W | Program address to write |
| ld_word | input | IW | Instruction word to write |
| halted | output | 1 | Execution has stopped |
| fault | output | 1 | Stopped on an operand outside the register bank |
| ip | output | PC_W | Instruction pointer |
| dbg_sel | input | RA_W | Register number for the debug read |
| dbg_val | output | DATA_W | Value of the selected register |

## Verification
Two corners are hard to reach from the ports. The first is increment saturation, because registers start at zero and only increment can raise them. The stimulus is a four-instruction loop that copies the register, increments it, and stops once a compare finds the value unchanged, which happens only after 255 passes. The second is the fault. A pointer must hold a value beyond the bank size, so sixteen increments build that value before an indirect access uses it. The four copy variants need pointers and data set up first, so each program begins with an increment preamble.

// File: rtl/regm_pkg.sv
package regm_pkg;
  typedef enum logic [2:0] {
    OP_HALT = 3'd0,
    OP_INC  = 3'd1,
    OP_DEC  = 3'd2,
    OP_CLR  = 3'd3,
    OP_CPY  = 3'd4,
    OP_JZ   = 3'd5,
    OP_JE   = 3'd6,
    OP_JMP  = 3'd7
  } opcode_e;

  typedef enum logic {PH_FETCH = 1'b0, PH_EXEC = 1'b1} phase_e;

  function automatic logic uses_a(opcode_e op);
    return (op != OP_HALT) && (op != OP_JMP);
  endfunction

  function automatic logic uses_b(opcode_e op);
    return (op == OP_CPY) || (op == OP_JE);
  endfunction
endpackage

// File: rtl/regm_rom.sv
module regm_rom #(
  parameter int IW   = 18,
  parameter int PC_W = 5
) (
  input  logic            clk,
  input  logic            we,
  input  logic [PC_W-1:0] waddr,
  input  logic [IW-1:0]   wdata,
  input  logic [PC_W-1:0] raddr,
  output logic [IW-1:0]   rdata
);
  localparam int DEPTH = 1 << PC_W;
  logic [IW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/regm_regfile.sv
module regm_regfile #(
  parameter int DATA_W = 8,
  parameter int NREGS  = 16,
  parameter int NRD    = 5,
  localparam int RA_W  = $clog2(NREGS)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NRD-1:0][RA_W-1:0]     ridx,
  output logic [NRD-1:0][DATA_W-1:0]   rdata,
  input  logic                         we,
  input  logic [RA_W-1:0]              waddr,
  input  logic [DATA_W-1:0]            wdata
);
  logic [DATA_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (we) begin
      regs[waddr] <= wdata;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = regs[ridx[g]];
  end
endmodule

// File: rtl/regm_resolve.sv
module regm_resolve #(
  parameter int DATA_W = 8,
  parameter int NREGS  = 16,
  localparam int RA_W  = $clog2(NREGS)
) (
  input  logic [RA_W-1:0]   fld,
  input  logic              ind,
  input  logic [DATA_W-1:0] ptr_val,
  output logic [RA_W-1:0]   eff,
  output logic              bad
);
  localparam logic [DATA_W:0] LIMIT = (DATA_W+1)'(NREGS);
  logic [DATA_W-1:0] full;

  assign full = ind ? ptr_val : DATA_W'(fld);
  assign bad  = {1'b0, full} >= LIMIT;
  assign eff  = full[RA_W-1:0];
endmodule

// File: rtl/regm_core.sv
module regm_core #(
  parameter int DATA_W = 8,
  parameter int NREGS  = 16,
  parameter int PC_W   = 5,
  localparam int RA_W  = $clog2(NREGS),
  localparam int IW    = 3 + 2 * (RA_W + 1) + PC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_en,
  input  logic [PC_W-1:0]   ld_addr,
  input  logic [IW-1:0]     ld_word,
  output logic              halted,
  output logic              fault,
  output logic [PC_W-1:0]   ip,
  input  logic [RA_W-1:0]   dbg_sel,
  output logic [DATA_W-1:0] dbg_val
);
  import regm_pkg::*;

  localparam logic [DATA_W-1:0] VMAX = '1;

  logic [IW-1:0] word;
  opcode_e       op_w, op_q;
  logic [1:0]    ind_w;
  logic [1:0][RA_W-1:0] fld_w, eff;
  logic [1:0]    bad;
  logic [PC_W-1:0] z_q;
  logic [RA_W-1:0] ea_q, eb_q;
  logic          bad_q;
  phase_e        phase;
  logic          exec;

  logic [4:0][RA_W-1:0]   ridx;
  logic [4:0][DATA_W-1:0] rval;
  logic [DATA_W-1:0]      va, vb, wdata;
  logic                   we;

  regm_rom #(.IW(IW), .PC_W(PC_W)) rom_i (
    .clk(clk), .we(ld_en), .waddr(ld_addr), .wdata(ld_word),
    .raddr(ip), .rdata(word)
  );

  // Field split of the fetched word.
  assign op_w     = opcode_e'(word[IW-1 -: 3]);
  assign ind_w[0] = word[IW-4];
  assign fld_w[0] = word[IW-5 -: RA_W];
  assign ind_w[1] = word[IW-5-RA_W];
  assign fld_w[1] = word[IW-6-RA_W -: RA_W];

  // Read ports: 0/1 pointer reads, 2/3 target reads, 4 debug.
  assign ridx = {dbg_sel, eb_q, ea_q, fld_w[1], fld_w[0]};
  assign va = rval[2];
  assign vb = rval[3];
  assign dbg_val = rval[4];

  regm_regfile #(.DATA_W(DATA_W), .NREGS(NREGS), .NRD(5)) rf_i (
    .clk(clk), .rst_n(rst_n), .ridx(ridx), .rdata(rval),
    .we(we), .waddr(ea_q), .wdata(wdata)
  );

  for (genvar g = 0; g < 2; g++) begin : g_opnd
    regm_resolve #(.DATA_W(DATA_W), .NREGS(NREGS)) res_i (
      .fld(fld_w[g]), .ind(ind_w[g]), .ptr_val(rval[g]),
      .eff(eff[g]), .bad(bad[g])
    );
  end

  assign exec = (phase == PH_EXEC) && !halted;

  always_comb begin
    we    = 1'b0;
    wdata = va;
    if (exec && !bad_q) begin
      unique case (op_q)
        OP_INC: begin we = 1'b1; wdata = (va == VMAX) ? VMAX : va + 1'b1; end
        OP_DEC: begin we = 1'b1; wdata = (va == '0) ? '0 : va - 1'b1; end
        OP_CLR: begin we = 1'b1; wdata = '0; end
        OP_CPY: begin we = 1'b1; wdata = vb; end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_FETCH;
      ip     <= '0;
      halted <= 1'b0;
      fault  <= 1'b0;
      op_q   <= OP_HALT;
      z_q    <= '0;
      ea_q   <= '0;
      eb_q   <= '0;
      bad_q  <= 1'b0;
    end else if (!halted) begin
      if (phase == PH_FETCH) begin
        op_q  <= op_w;
        z_q   <= word[PC_W-1:0];
        ea_q  <= eff[0];
        eb_q  <= eff[1];
        bad_q <= (uses_a(op_w) && bad[0]) || (uses_b(op_w) && bad[1]);
        phase <= PH_EXEC;
      end else begin
        phase <= PH_FETCH;
        if (bad_q) begin
          fault  <= 1'b1;
          halted <= 1'b1;
        end else begin
          unique case (op_q)
            OP_HALT: halted <= 1'b1;
            OP_JMP:  ip <= z_q;
            OP_JZ:   ip <= (va == '0) ? z_q : ip + 1'b1;
            OP_JE:   ip <= (va == vb) ? z_q : ip + 1'b1;
            default: ip <= ip + 1'b1;
          endcase
        end
      end
    end
  end

  a_r11_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted && $stable(ip));

  a_r12_fault_halts: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> halted);

  a_r12_no_move_on_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && bad_q) |=> fault && $stable(ip));

  a_r2_single_exec: assert property (@(posedge clk) disable iff (!rst_n)
    exec |=> !exec);

  a_r8_jz_taken: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !bad_q && op_q == OP_JZ && va == '0) |=> ip == $past(z_q));

  a_r3_inc_step: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !bad_q && op_q == OP_INC) |=> ip == PC_W'($past(ip) + 1'b1));
endmodule

// File: tb/regm_core_tb_top.sv
`timescale 1ns/1ps
module regm_core_tb_top;
  localparam int DW = 8, NR = 16, PW = 5, RW = 4, IW = 18;
  localparam int HALT = 0, INC = 1, DEC = 2, CLR = 3, CPY = 4, JZ = 5, JE = 6, JMP = 7;

  logic clk = 1'b0, rst_n = 1'b0, ld_en = 1'b0;
  logic [PW-1:0] ld_addr = '0;
  logic [IW-1:0] ld_word = '0;
  logic halted, fault;
  logic [PW-1:0] ip;
  logic [RW-1:0] dbg_sel = '0;
  logic [DW-1:0] dbg_val;

  regm_core #(.DATA_W(DW), .NREGS(NR), .PC_W(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_word(ld_word),
    .halted(halted), .fault(fault), .ip(ip), .dbg_sel(dbg_sel), .dbg_val(dbg_val)
  );

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0, cyc_all = 0;
  logic [IW-1:0] prog [32];

  always @(posedge clk) begin
    cyc_all++;
    if (cyc_all > 150000) begin
      n_fail++;
      $display("FAIL watchdog: run did not end, act=%0d cycles exp<150000", cyc_all);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [IW-1:0] mk(int op, bit ia, int a, bit ib, int b, int z);
    return {op[2:0], ia, a[3:0], ib, b[3:0], z[4:0]};
  endfunction

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = '0;
  endtask

  task automatic load_hold();
    @(negedge clk) rst_n = 1'b0;
    for (int i = 0; i < 32; i++) begin
      ld_en = 1'b1; ld_addr = PW'(i); ld_word = prog[i];
      @(negedge clk);
    end
    ld_en = 1'b0;
  endtask

  task automatic start();
    rst_n = 1'b1;
  endtask

  task automatic wait_halt();
    int c = 0;
    while (!halted && c < 8000) begin @(negedge clk); c++; end
  endtask

  task automatic peek(input int r, output int v);
    dbg_sel = RW'(r);
    #1 v = dbg_val;
  endtask

  // R1: reset state, after a run has dirtied the bank
  task automatic t_reset();
    int v;
    clear_prog();
    prog[0] = mk(INC, 0, 1, 0, 0, 0);
    prog[1] = mk(INC, 0, 7, 0, 0, 0);
    load_hold(); start(); wait_halt();
    load_hold();
    chk("R1", "ip in reset", ip, 0);
    chk("R1", "halted in reset", halted, 0);
    chk("R1", "fault in reset", fault, 0);
    peek(1, v); chk("R1", "r1 cleared", v, 0);
    peek(7, v); chk("R1", "r7 cleared", v, 0);
  endtask

  // R2: two cycles per instruction
  task automatic t_timing();
    clear_prog();
    for (int i = 0; i < 3; i++) prog[i] = mk(INC, 0, 1, 0, 0, 0);
    load_hold(); start();
    repeat (7) @(negedge clk);
    chk("R2", "halted after 7 edges", halted, 0);
    @(negedge clk);
    chk("R2", "halted after 8 edges", halted, 1);
    chk("R2", "ip at halt", ip, 3);
  endtask

  // R3 R4 R5 R11: direct arithmetic, floor at zero, halt freeze
  task automatic t_arith();
    int v, ip0;
    clear_prog();
    prog[0] = mk(INC, 0, 1, 0, 0, 0);
    prog[1] = mk(INC, 0, 1, 0, 0, 0);
    prog[2] = mk(INC, 0, 1, 0, 0, 0);
    prog[3] = mk(DEC, 0, 1, 0, 0, 0);
    prog[4] = mk(INC, 0, 2, 0, 0, 0);
    prog[5] = mk(CLR, 0, 2, 0, 0, 0);
    prog[6] = mk(DEC, 0, 3, 0, 0, 0);
    prog[7] = mk(CPY, 0, 4, 0, 1, 0);
    prog[8] = mk(HALT, 0, 0, 0, 0, 0);
    prog[9] = mk(INC, 0, 1, 0, 0, 0);
    load_hold(); start(); wait_halt();
    peek(1, v); chk("R3", "r1 after 3 inc 1 dec", v, 2);
    peek(2, v); chk("R5", "r2 cleared", v, 0);
    peek(3, v); chk("R4", "r3 dec floor", v, 0);
    peek(4, v); chk("R5", "r4 copied from r1", v, 2);
    ip0 = ip;
    chk("R11", "ip at halt", ip0, 8);
    repeat (10) @(negedge clk);
    chk("R11", "ip frozen", ip, 8);
    peek(1, v); chk("R11", "r1 frozen", v, 2);
  endtask

  // R3: increment saturation via unchanged-value loop
  task automatic t_saturate();
    int v;
    clear_prog();
    prog[0] = mk(CPY, 0, 6, 0, 2, 0);
    prog[1] = mk(INC, 0, 2, 0, 0, 0);
    prog[2] = mk(JE, 0, 2, 0, 6, 4);
    prog[3] = mk(JMP, 0, 0, 0, 0, 0);
    load_hold(); start(); wait_halt();
    chk("R3", "saturation loop halted", halted, 1);
    peek(2, v); chk("R3", "r2 saturated", v, 255);
    chk("R9", "ip after equal exit", ip, 4);
  endtask

  // R6 R7: pointer operands, four copy variants, self pointer
  task automatic t_indirect();
    int v, a;
    clear_prog();
    a = 0;
    for (int i = 0; i < 4; i++) begin prog[a] = mk(INC, 0, 1, 0, 0, 0); a++; end
    for (int i = 0; i < 5; i++) begin prog[a] = mk(INC, 0, 2, 0, 0, 0); a++; end
    for (int i = 0; i < 2; i++) begin prog[a] = mk(INC, 0, 5, 0, 0, 0); a++; end
    prog[a] = mk(CPY, 0, 7, 0, 1, 0); a++;
    prog[a] = mk(CPY, 1, 1, 0, 2, 0); a++;
    prog[a] = mk(CPY, 0, 8, 1, 2, 0); a++;
    prog[a] = mk(CPY, 1, 2, 1, 1, 0); a++;
    load_hold(); start(); wait_halt();
    peek(7, v); chk("R7", "direct/direct r7", v, 4);
    peek(4, v); chk("R7", "pointer dest r4", v, 5);
    peek(8, v); chk("R7", "pointer src r8", v, 2);
    peek(5, v); chk("R7", "both pointers r5", v, 5);
    clear_prog();
    for (int i = 0; i < 9; i++) prog[i] = mk(INC, 0, 9, 0, 0, 0);
    prog[9] = mk(INC, 1, 9, 0, 0, 0);
    load_hold(); start(); wait_halt();
    peek(9, v); chk("R6", "self pointer r9", v, 10);
  endtask

  // R8 R9 R10: control flow
  task automatic t_branch();
    int v;
    clear_prog();
    prog[0]  = mk(INC, 0, 1, 0, 0, 0);
    prog[1]  = mk(INC, 0, 1, 0, 0, 0);
    prog[2]  = mk(INC, 0, 1, 0, 0, 0);
    prog[3]  = mk(JZ, 0, 1, 0, 0, 7);
    prog[4]  = mk(DEC, 0, 1, 0, 0, 0);
    prog[5]  = mk(INC, 0, 2, 0, 0, 0);
    prog[6]  = mk(JMP, 0, 0, 0, 0, 3);
    prog[7]  = mk(JE, 0, 1, 0, 3, 9);
    prog[8]  = mk(INC, 0, 4, 0, 0, 0);
    prog[9]  = mk(JE, 0, 2, 0, 1, 11);
    prog[10] = mk(INC, 0, 5, 0, 0, 0);
    load_hold(); start(); wait_halt();
    peek(2, v); chk("R8", "loop count r2", v, 3);
    peek(4, v); chk("R9", "equal jump skipped r4", v, 0);
    peek(5, v); chk("R9", "unequal fall-through r5", v, 1);
    chk("R10", "final ip", ip, 11);
  endtask

  // R12: pointer beyond bank
  task automatic t_fault();
    int v;
    clear_prog();
    for (int i = 0; i < 16; i++) prog[i] = mk(INC, 0, 1, 0, 0, 0);
    prog[16] = mk(INC, 1, 1, 0, 0, 0);
    prog[17] = mk(INC, 0, 0, 0, 0, 0);
    load_hold(); start(); wait_halt();
    chk("R12", "fault", fault, 1);
    chk("R12", "halted", halted, 1);
    chk("R12", "ip on faulting word", ip, 16);
    peek(1, v); chk("R12", "pointer unchanged", v, 16);
    peek(0, v); chk("R12", "next word not run", v, 0);
  endtask

  initial begin
    t_reset();
    t_timing();
    t_arith();
    t_saturate();
    t_indirect();
    t_branch();
    t_fault();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule